// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is a compact sequencer that steps through a program of 22-bit instruction words held in an external program store addressed by an 8-bit program counter. Each word carries a 4-bit operation code, three 6-bit operand selectors and immediate fields that overlap them. An operand selector names either one of sixteen 16-bit signed registers or a word of an external data SRAM. The operation set covers jumps and conditional jumps, copy, add, subtract, multiply into a hidden product register, a read-back of that product through an arithmetic right shift, left and right shifts, loading a 12-bit constant, waiting for an external event pulse, and two operations that hand control to an external trigonometric engine and stall until it is done.

The program store is read combinationally at the program counter. The data SRAM has a one-cycle read latency. An instruction whose A operand is an SRAM word therefore takes two clocks: one to issue the read and one to complete. Every other instruction takes one clock. The exceptions are the event wait and the engine hand-off, which take as long as the external side needs.

Top module: `seq_core`

## Requirements
- R1: Reset sets the program counter to 0 and clears the product register and all registers. A right shift of the product by 0 and a copy of any register, both taken straight after reset, each write 0.
- R2: A jump (opcode 0) loads I1 into the program counter in one clock, and the next program address is I1.
- R3: Opcodes 1, 2 and 3 jump to I1 when operand A is negative, strictly positive or zero respectively. Otherwise the program counter advances by one. Zero counts as neither negative nor positive.
- R4: Copy (opcode 4) writes A to destination C. Immediate load (opcode 13) writes the 12-bit I2, zero-extended, to C. An SRAM destination appears as one write strobe with address and data.
- R5: Add (opcode 5) writes A+B and subtract (opcode 6) writes A−B to C, both wrapping modulo 2^16. B is always a register.
- R6: Multiply (opcode 9) stores the signed 32-bit product A·B in a hidden register and writes nothing else. Opcode 10 writes the low 16 bits of that product, arithmetically shifted right by I3, to C.
- R7: Opcode 11 writes A shifted left by I3 to C. Opcode 12 writes A shifted arithmetically right by I3 to C.
- R8: An instruction that reads A from SRAM holds the program address for exactly two clocks and issues exactly one read strobe, in its first clock. An instruction with register operands holds it for one clock.
- R9: The event wait (opcode 14) holds the program counter in every clock where the event input is 0. It advances in the clock where the input is 1.
- R10: Opcodes 7 and 8 raise a one-clock start strobe, with the engine select output 0 for opcode 7 and 1 for opcode 8 and the iteration output equal to bits [3:0] of register 15. The program counter then holds until the done input is 1 and advances in that clock.
- R11: Opcode 15 writes nothing and advances the program counter by one in one clock.
- R12: The word layout is opcode [21:18], A [17:12], B [11:6], C [5:0], I1 [7:0], I2 [17:6] and I3 [9:6]. A selector with bit 5 set names SRAM word [4:0]. A selector with bit 5 clear names register [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progAddr | output | 8 | Program counter, address into the program store |
| progData | input | 22 | Instruction word at progAddr |
| memRdEn | output | 1 | SRAM read strobe |
| memRdAddr | output | 5 | SRAM read address |
| memRdData | input | 16 | SRAM read data, valid one clock after the strobe |
| memWrEn | output | 1 | SRAM write strobe |
| memWrAddr | output | 5 | SRAM write address |
| memWrData | output | 16 | SRAM write data |
| syncPulse | input | 1 | Event input released by the wait operation |
| trigStart | output | 1 | One-clock start strobe to the trigonometric engine |
| trigOp | output | 1 | Engine select: 0 divide, 1 rotate |
| trigIter | output | 4 | Iteration count taken from register 15 |
| trigDone | input | 1 | Engine completion |

## Verification
A wrong register or product value stays hidden until a later copy, arithmetic or shift sends it to SRAM. It then shows as a wrong write data word in that instruction's completing clock, so the scoreboard checks every SRAM write against a precomputed expectation. A corrupt sequencing state shows more quickly, as a wrong dwell time of the program address: one clock too many or too few on an SRAM-operand, wait or engine instruction. Wrong branch evaluation shows as a visit to an address that should be skipped, which also produces a stray write to a poisoned SRAM word.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int InstrW   = 22;
  localparam int PcW      = 8;
  localparam int SelW     = 6;
  localparam int MemAddrW = SelW - 1;
  localparam int ImmW     = 12;
  localparam int ShW      = 4;
  localparam int OpLsb    = InstrW - 4;

  typedef enum logic [3:0] {
    OP_JMP  = 4'd0,
    OP_BRN  = 4'd1,
    OP_BRP  = 4'd2,
    OP_BRZ  = 4'd3,
    OP_ST   = 4'd4,
    OP_ADD  = 4'd5,
    OP_SUB  = 4'd6,
    OP_DIV  = 4'd7,
    OP_CORD = 4'd8,
    OP_MUL  = 4'd9,
    OP_SHMR = 4'd10,
    OP_SHL  = 4'd11,
    OP_SHR  = 4'd12,
    OP_STI  = 4'd13,
    OP_SYNC = 4'd14,
    OP_RSV  = 4'd15
  } opcode_e;

  typedef enum logic [2:0] {
    RES_PASS,
    RES_ADD,
    RES_SUB,
    RES_SHL,
    RES_SHR,
    RES_SHM,
    RES_IMM
  } resSel_e;

  typedef struct packed {
    logic    writeDest;
    logic    loadM;
    logic    aFromMem;
    resSel_e resSel;
  } dpCtrl_t;

  function automatic logic readsA(opcode_e op);
    return op inside {OP_BRN, OP_BRP, OP_BRZ, OP_ST, OP_ADD, OP_SUB,
                      OP_MUL, OP_SHL, OP_SHR};
  endfunction

  function automatic logic writesDest(opcode_e op);
    return op inside {OP_ST, OP_ADD, OP_SUB, OP_SHMR, OP_SHL, OP_SHR, OP_STI};
  endfunction

  function automatic resSel_e resultFor(opcode_e op);
    case (op)
      OP_ADD:  return RES_ADD;
      OP_SUB:  return RES_SUB;
      OP_SHL:  return RES_SHL;
      OP_SHR:  return RES_SHR;
      OP_SHMR: return RES_SHM;
      OP_STI:  return RES_IMM;
      default: return RES_PASS;
    endcase
  endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [InstrW-1:0]   instr,
  input  logic                aNeg,
  input  logic                aZero,
  input  logic                syncPulse,
  input  logic                trigDone,
  output logic [PcW-1:0]      pc,
  output logic                memRdEn,
  output logic [MemAddrW-1:0] memRdAddr,
  output logic                trigStart,
  output logic                trigOp,
  output dpCtrl_t             ctl
);

  typedef enum logic [1:0] {ST_EXEC, ST_OPND, ST_TRIG} state_e;

  state_e         state, stateN;
  logic [PcW-1:0] pcN, pcInc, target;
  opcode_e        op;
  logic [SelW-1:0] aSel;
  logic           needMem, isBranch, brTaken, ready;

  assign op       = opcode_e'(instr[InstrW-1:OpLsb]);
  assign aSel     = instr[OpLsb-1:OpLsb-SelW];
  assign target   = instr[PcW-1:0];
  assign pcInc    = pc + PcW'(1);
  assign needMem  = readsA(op) && aSel[SelW-1];
  assign isBranch = op inside {OP_BRN, OP_BRP, OP_BRZ};

  always_comb begin
    case (op)
      OP_BRN:  brTaken = aNeg;
      OP_BRP:  brTaken = !aNeg && !aZero;
      OP_BRZ:  brTaken = aZero;
      default: brTaken = 1'b0;
    endcase
  end

  always_comb begin
    stateN    = state;
    pcN       = pc;
    trigStart = 1'b0;
    memRdEn   = 1'b0;
    ready     = 1'b0;
    case (state)
      ST_EXEC: begin
        if (op == OP_JMP) begin
          pcN = target;
        end else if (op == OP_DIV || op == OP_CORD) begin
          trigStart = 1'b1;
          stateN    = ST_TRIG;
        end else if (op == OP_SYNC) begin
          if (syncPulse) pcN = pcInc;
        end else if (needMem) begin
          memRdEn = 1'b1;
          stateN  = ST_OPND;
        end else begin
          ready = 1'b1;
          pcN   = (isBranch && brTaken) ? target : pcInc;
        end
      end
      ST_OPND: begin
        ready  = 1'b1;
        pcN    = (isBranch && brTaken) ? target : pcInc;
        stateN = ST_EXEC;
      end
      ST_TRIG: begin
        if (trigDone) begin
          pcN    = pcInc;
          stateN = ST_EXEC;
        end
      end
      default: stateN = ST_EXEC;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_EXEC;
      pc    <= '0;
    end else begin
      state <= stateN;
      pc    <= pcN;
    end
  end

  assign memRdAddr     = aSel[MemAddrW-1:0];
  assign trigOp        = (op == OP_CORD);
  assign ctl.writeDest = ready && writesDest(op);
  assign ctl.loadM     = ready && (op == OP_MUL);
  assign ctl.aFromMem  = (state == ST_OPND);
  assign ctl.resSel    = resultFor(op);

  assert_stall_once_R8: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (!memRdEn && $stable(pc)));

  assert_sync_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXEC && op == OP_SYNC && !syncPulse) |=> $stable(pc));

  assert_trig_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    trigStart |=> !trigStart);

  assert_trig_wait_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TRIG && !trigDone) |=> $stable(pc));

  assert_jump_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXEC && op == OP_JMP) |=> (pc == $past(target)));

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int DataW   = 16,
  parameter int NumRegs = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SelW-1:0]     aSel,
  input  logic [SelW-1:0]     bSel,
  input  logic [SelW-1:0]     cSel,
  input  logic [ImmW-1:0]     imm,
  input  logic [ShW-1:0]      shAmt,
  input  dpCtrl_t             ctl,
  input  logic [DataW-1:0]    memRdData,
  output logic                memWrEn,
  output logic [MemAddrW-1:0] memWrAddr,
  output logic [DataW-1:0]    memWrData,
  output logic                aNeg,
  output logic                aZero,
  output logic [3:0]          iterCount
);

  localparam int RegIdxW = $clog2(NumRegs);
  localparam int ProdW   = 2 * DataW;

  logic signed [DataW-1:0] regs [NumRegs];
  logic signed [DataW-1:0] opA, opB, res;
  logic signed [ProdW-1:0] aWide, bWide, mReg, mShifted;
  logic                    regWe;

  assign opA      = ctl.aFromMem ? memRdData : regs[aSel[RegIdxW-1:0]];
  assign opB      = regs[bSel[RegIdxW-1:0]];
  assign aWide    = opA;
  assign bWide    = opB;
  assign mShifted = mReg >>> shAmt;

  always_comb begin
    case (ctl.resSel)
      RES_ADD: res = opA + opB;
      RES_SUB: res = opA - opB;
      RES_SHL: res = opA << shAmt;
      RES_SHR: res = opA >>> shAmt;
      RES_SHM: res = mShifted[DataW-1:0];
      RES_IMM: res = DataW'(imm);
      default: res = opA;
    endcase
  end

  assign regWe     = ctl.writeDest && !cSel[SelW-1];
  assign memWrEn   = ctl.writeDest && cSel[SelW-1];
  assign memWrAddr = cSel[MemAddrW-1:0];
  assign memWrData = res;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NumRegs; i++) regs[i] <= '0;
    end else if (regWe) begin
      regs[cSel[RegIdxW-1:0]] <= res;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          mReg <= '0;
    else if (ctl.loadM) mReg <= aWide * bWide;
  end

  assign aNeg      = opA[DataW-1];
  assign aZero     = (opA == '0);
  assign iterCount = regs[NumRegs-1][3:0];

  assert_m_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadM |=> $stable(mReg));

endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_pkg::*;
#(
  parameter int DataW   = 16,
  parameter int NumRegs = 16
) (
  input  logic                clk,
  input  logic                rstN,
  output logic [PcW-1:0]      progAddr,
  input  logic [InstrW-1:0]   progData,
  output logic                memRdEn,
  output logic [MemAddrW-1:0] memRdAddr,
  input  logic [DataW-1:0]    memRdData,
  output logic                memWrEn,
  output logic [MemAddrW-1:0] memWrAddr,
  output logic [DataW-1:0]    memWrData,
  input  logic                syncPulse,
  output logic                trigStart,
  output logic                trigOp,
  output logic [3:0]          trigIter,
  input  logic                trigDone
);

  dpCtrl_t ctl;
  logic    aNeg, aZero;

  seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instr     (progData),
    .aNeg      (aNeg),
    .aZero     (aZero),
    .syncPulse (syncPulse),
    .trigDone  (trigDone),
    .pc        (progAddr),
    .memRdEn   (memRdEn),
    .memRdAddr (memRdAddr),
    .trigStart (trigStart),
    .trigOp    (trigOp),
    .ctl       (ctl)
  );

  seq_datapath #(.DataW(DataW), .NumRegs(NumRegs)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .aSel      (progData[17:12]),
    .bSel      (progData[11:6]),
    .cSel      (progData[5:0]),
    .imm       (progData[17:6]),
    .shAmt     (progData[9:6]),
    .ctl       (ctl),
    .memRdData (memRdData),
    .memWrEn   (memWrEn),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData),
    .aNeg      (aNeg),
    .aZero     (aZero),
    .iterCount (trigIter)
  );

endmodule

// File: tb/seq_core_tb.sv
`timescale 1ns/1ps
module seq_core_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  progAddr;
  logic [21:0] progData;
  logic        memRdEn, memWrEn, trigStart, trigOp;
  logic [4:0]  memRdAddr, memWrAddr;
  logic [15:0] memRdData, memWrData;
  logic [3:0]  trigIter;
  logic        syncPulse = 1'b0;
  logic        trigDone = 1'b0;

  logic [21:0] rom [256];
  logic [15:0] sram [32];
  int          dwell [256];
  int          total = 0;
  int          bad = 0;
  int          cycles = 0;
  int          trigSeen = 0;
  int          ptr = 0;

  logic [4:0]  expA [$];
  logic [15:0] expD [$];
  string       expTag [$];

  always #5 clk = ~clk;

  seq_core u_dut (
    .clk(clk), .rstN(rstN), .progAddr(progAddr), .progData(progData),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .syncPulse(syncPulse), .trigStart(trigStart), .trigOp(trigOp),
    .trigIter(trigIter), .trigDone(trigDone)
  );

  assign progData = rom[progAddr];

  always @(posedge clk) begin
    if (rstN && memRdEn) memRdData <= sram[memRdAddr];
    if (rstN && memWrEn) sram[memWrAddr] <= memWrData;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] rs(input int n); return {2'b00, 4'(n)}; endfunction
  function automatic logic [5:0] ms(input int n); return {1'b1, 5'(n)}; endfunction

  task automatic put(input logic [21:0] w); rom[ptr] = w; ptr++; endtask
  task automatic opR(input int op, input logic [5:0] a, b, c);
    put({4'(op), a, b, c});
  endtask
  task automatic opBr(input int op, input logic [5:0] a, input int tgt);
    put({4'(op), a, 4'b0, 8'(tgt)});
  endtask
  task automatic opImm(input int imm, input logic [5:0] c);
    put({4'd13, 12'(imm), c});
  endtask
  task automatic opSh(input int op, input logic [5:0] a, input int sh, input logic [5:0] c);
    put({4'(op), a, 2'b00, 4'(sh), c});
  endtask
  task automatic expect_wr(input int a, input int d, input string tag);
    expA.push_back(5'(a)); expD.push_back(16'(d)); expTag.push_back(tag);
  endtask

  // scoreboard monitor and dwell counter
  always @(negedge clk) begin
    if (rstN) begin
      cycles++;
      dwell[progAddr]++;
      if (memWrEn) begin
        if (expA.size() == 0) begin
          check(1'b0, "R3 unexpected write", int'(memWrAddr), 0);
        end else begin
          logic [4:0] ea; logic [15:0] ed; string et;
          ea = expA.pop_front(); ed = expD.pop_front(); et = expTag.pop_front();
          check(memWrAddr == ea, {et, " addr"}, int'(memWrAddr), int'(ea));
          check(memWrData == ed, {et, " data"}, int'(memWrData), int'(ed));
        end
      end
    end
  end

  // trigonometric engine model: R10
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && trigStart) begin
        if (trigSeen == 0) begin
          check(trigOp == 1'b0, "R10 op", int'(trigOp), 0);
          check(trigIter == 4'd9, "R10 iter", int'(trigIter), 9);
        end else begin
          check(trigOp == 1'b1, "R10 op", int'(trigOp), 1);
          check(trigIter == 4'd12, "R10 iter", int'(trigIter), 12);
        end
        trigSeen++;
        repeat (10) @(negedge clk);
        trigDone = 1'b1;
        @(negedge clk);
        trigDone = 1'b0;
      end
    end
  end

  // event source for the wait instruction: R9
  initial begin
    @(negedge clk);
    while (!(rstN && progAddr == 8'd41)) @(negedge clk);
    repeat (4) @(negedge clk);
    syncPulse = 1'b1;
    @(negedge clk);
    syncPulse = 1'b0;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin rom[i] = {4'd15, 18'd0}; dwell[i] = 0; end
    for (int i = 0; i < 32; i++) sram[i] = '0;
    memRdData = '0;

    opSh(10, rs(0), 0, ms(8));            expect_wr(8, 0, "R1 product reset");
    opR(4, rs(9), rs(0), ms(9));          expect_wr(9, 0, "R1 register reset");
    opImm(100, rs(1));
    opImm(7, rs(2));
    opR(5, rs(1), rs(2), rs(3));
    opR(4, rs(3), rs(0), ms(0));          expect_wr(0, 107, "R4 R5 add copy");
    opR(6, rs(2), rs(1), rs(4));
    opR(4, rs(4), rs(0), ms(1));          expect_wr(1, 16'hFFA3, "R5 sub");
    opSh(11, rs(2), 3, ms(2));            expect_wr(2, 56, "R7 R12 shl");
    opSh(12, rs(4), 2, ms(3));            expect_wr(3, 16'hFFE8, "R7 shr arith");
    opR(9, rs(1), rs(2), rs(0));
    opSh(10, rs(0), 1, ms(4));            expect_wr(4, 350, "R6 product");
    opImm(12'h7FF, rs(7));
    opSh(11, rs(7), 4, rs(7));
    opR(5, rs(7), rs(7), ms(5));          expect_wr(5, 16'hFFE0, "R5 add wrap");
    opR(6, rs(4), rs(7), ms(10));         expect_wr(10, 16'h7FB3, "R5 sub wrap");
    opR(5, ms(0), rs(2), ms(6));          expect_wr(6, 114, "R8 sram operand");
    opImm(12'hFFF, rs(0));
    opSh(11, rs(0), 4, rs(0));
    opR(9, ms(0), rs(2), rs(0));
    opSh(10, rs(0), 2, ms(11));           expect_wr(11, 187, "R6 R8 product of sram");
    opR(9, rs(0), rs(2), rs(0));
    opSh(10, rs(0), 3, ms(12));           expect_wr(12, 16'hFFF2, "R6 negative product");
    opBr(3, rs(9), 25);                   // 23
    opImm(12'hBAD, ms(7));                // 24 skipped
    opBr(1, rs(4), 27);                   // 25
    opImm(12'hBAD, ms(7));                // 26 skipped
    opBr(2, rs(4), 60);                   // 27 not taken
    opImm(12'h123, ms(13));               expect_wr(13, 16'h0123, "R3 R4 fall through");
    opBr(3, rs(1), 60);                   // 29 not taken
    opBr(2, rs(1), 32);                   // 30
    opImm(12'hBAD, ms(7));                // 31 skipped
    opBr(1, ms(1), 34);                   // 32 sram operand
    opImm(12'hBAD, ms(7));                // 33 skipped
    opBr(2, rs(9), 60);                   // 34 zero is not positive
    opBr(1, rs(1), 60);                   // 35
    opR(15, rs(0), rs(0), ms(7));         // 36 reserved
    opImm(9, rs(15));                     // 37
    opR(7, rs(0), rs(0), rs(0));          // 38
    opImm(12, rs(15));                    // 39
    opR(8, rs(0), rs(0), rs(0));          // 40
    opR(14, rs(0), rs(0), rs(0));         // 41
    opImm(12'hABC, ms(14));               expect_wr(14, 16'h0ABC, "R9 after wait");
    opBr(0, rs(0), 45);                   // 43
    opImm(12'hBAD, ms(7));                // 44 skipped
    opBr(0, rs(0), 45);                   // 45 halt
    rom[60] = {4'd13, 12'hBAD, ms(7)};

    repeat (3) @(negedge clk);
    check(progAddr == 8'd0, "R1 pc in reset", int'(progAddr), 0);
    check(trigStart == 1'b0, "R1 no start in reset", int'(trigStart), 0);
    rstN = 1'b1;

    while (!(progAddr == 8'd45 && expA.size() == 0 && cycles > 60) && cycles < 3000)
      @(negedge clk);
    repeat (3) @(negedge clk);
    check(cycles < 3000, "watchdog", cycles, 3000);
    check(expA.size() == 0, "R4 pending writes", expA.size(), 0);

    check(dwell[4] == 1, "R8 register op dwell", dwell[4], 1);
    check(dwell[5] == 1, "R8 register op dwell", dwell[5], 1);
    check(dwell[16] == 2, "R8 sram op dwell", dwell[16], 2);
    check(dwell[19] == 2, "R8 sram mul dwell", dwell[19], 2);
    check(dwell[32] == 2, "R8 sram branch dwell", dwell[32], 2);
    check(dwell[24] == 0, "R3 skip zero", dwell[24], 0);
    check(dwell[26] == 0, "R3 skip neg", dwell[26], 0);
    check(dwell[31] == 0, "R3 skip pos", dwell[31], 0);
    check(dwell[33] == 0, "R3 skip sram neg", dwell[33], 0);
    check(dwell[60] == 0, "R3 untaken target", dwell[60], 0);
    check(dwell[44] == 0, "R2 jump skip", dwell[44], 0);
    check(dwell[43] == 1, "R2 jump one clock", dwell[43], 1);
    check(dwell[36] == 1, "R11 reserved op", dwell[36], 1);
    check(dwell[37] == 1, "R11 next after reserved", dwell[37], 1);
    check(dwell[38] == 11, "R10 divide hold", dwell[38], 11);
    check(dwell[40] == 11, "R10 rotate hold", dwell[40], 11);
    check(trigSeen == 2, "R10 start count", trigSeen, 2);
    check(dwell[41] == 5, "R9 wait hold", dwell[41], 5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule